// File: doc/BRIEF.md
# Serial Module Stop and Freeze Controller

This block handles low-power stop and debug freeze for a serial module with two channels. A small configuration register on the host bus holds three settings: a stop bit, a two-bit freeze mode and a clear-to-send capture clock select. When stop is set, the block gates the enables of the crystal-derived clock and the serial clock. It changes each enable only while that clock's level is low. The host-bus clock keeps running. While the module is stopped, the bus interface returns an error for any access to a module register other than the configuration register.

A debug freeze request halts units one at a time. Each channel has a transmitter and a receiver, and each of these four units freezes at its own next character boundary, provided the freeze mode honours the request. A transmitter that is sending a break never freezes. The block also samples each channel's clear-to-send input on the rising edge of the selected capture clock. The shift engines and the oscillators are outside this block. Their clocks arrive as level inputs sampled on the bus clock, and their character boundaries arrive as one-cycle pulses.

Top module: `sio_pm_ctrl`

## Requirements
- R1: After reset the configuration register reads 0 (stop 0, freeze mode 00, capture select 0), both clock enables are 1, every frozen flag is 0 and the captured clear-to-send bits are 0.
- R2: While stop is 1, each clock enable drops to 0 at the first bus-clock edge that sees its clock level low, and it stays 0 for as long as stop is 1.
- R3: A clock enable changes only on an edge that sees that clock's level low. After stop is cleared, the enable returns to 1 on the first edge that sees the level low.
- R4: Configuration layout: bit 0 is stop, bits 2:1 are freeze mode and bit 3 is capture select. The configuration register can be read and written at any time, and the response (ack with read data) comes one cycle after the request.
- R5: An access with cfg_sel=0 (any other module register) while stop is 1 gets bus_err=1 and bus_ack=0 one cycle later. When stop is 0, the same access gets bus_ack=1.
- R6: With freeze mode 00 or 01, a freeze request is ignored and no unit freezes, even at a character boundary.
- R7: With freeze mode 10 or 11 and a freeze request active, a unit freezes on the edge after its own boundary pulse. The unit index is 2*channel for the transmitter and 2*channel+1 for the receiver. Other units are unaffected.
- R8: A transmitter whose channel break flag is 1 does not freeze at its boundary. The receiver of the same channel still freezes.
- R9: Every frozen flag clears on the first edge that sees the freeze request low.
- R10: With capture select 0 the clear-to-send bits update from cts_in on a rising level of the crystal clock. With capture select 1 they update on a rising level of the serial clock. Rising levels of the other clock and steady levels leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host-bus clock, always running |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access request, one cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| cfg_sel | input | 1 | 1 = configuration register, 0 = any other module register |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Read data, valid with bus_ack |
| bus_ack | output | 1 | Normal completion |
| bus_err | output | 1 | Bus error completion |
| xtal_lvl | input | 1 | Level of the crystal-derived clock |
| sclk_lvl | input | 1 | Level of the serial clock |
| xtal_en | output | 1 | Enable for the crystal-derived clock |
| sclk_en | output | 1 | Enable for the serial clock |
| dbg_freeze | input | 1 | Debug freeze request |
| char_bnd | input | 4 | Per-unit character boundary pulses |
| brk_active | input | 2 | Per-channel transmitter break flag |
| frozen | output | 4 | Per-unit frozen status |
| cts_in | input | 2 | Per-channel clear-to-send inputs |
| cts_q | output | 2 | Captured clear-to-send bits |

## Verification
The assertions assume that the clock levels are already synchronous to the bus clock. They also assume that boundary pulses last one cycle, and that a bus request is never held across consecutive cycles. The bench drives every input on the falling bus-clock edge and issues each request for exactly one cycle. It changes a clock level only between checks, so every enable transition it expects falls on an edge where the level is known. The freeze sweep covers all modes, all units and both break values, and it releases the request between combinations so that each one starts unfrozen.

// File: rtl/sio_pm_pkg.sv
package sio_pm_pkg;

  typedef struct packed {
    logic       capsel;
    logic [1:0] frz_mode;
    logic       stop;
  } sio_cfg_t;

  localparam int CFG_W = $bits(sio_cfg_t);

  function automatic logic frz_honored(input logic [1:0] mode);
    return mode[1];
  endfunction

  function automatic logic unit_is_tx(input int unsigned u);
    return (u % 2) == 0;
  endfunction

  function automatic int unsigned unit_chan(input int unsigned u);
    return u / 2;
  endfunction

  function automatic logic rise(input logic lvl, input logic prev, input logic en);
    return lvl & ~prev & en;
  endfunction

endpackage

// File: rtl/sio_cfg_bus.sv
module sio_cfg_bus
  import sio_pm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_req,
  input  logic             bus_wr,
  input  logic             cfg_sel,
  input  logic [CFG_W-1:0] bus_wdata,
  output logic [CFG_W-1:0] bus_rdata,
  output logic             bus_ack,
  output logic             bus_err,
  output sio_cfg_t         cfg
);

  logic blocked;
  logic cfg_wr;

  assign blocked = bus_req & cfg.stop & ~cfg_sel;
  assign cfg_wr  = bus_req & bus_wr & cfg_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg       <= '0;
      bus_ack   <= 1'b0;
      bus_err   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (cfg_wr) cfg <= sio_cfg_t'(bus_wdata);
      bus_ack   <= bus_req & ~blocked;
      bus_err   <= blocked;
      bus_rdata <= (bus_req & cfg_sel & ~bus_wr) ? cfg : '0;
    end
  end

  AST_RESP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_ack && bus_err)); // R5
  AST_ERR_NEEDS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_err) |-> $past(cfg.stop)); // R5
  AST_CFG_NEVER_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && cfg_sel) |=> !bus_err); // R4

endmodule

// File: rtl/sio_clk_gate.sv
module sio_clk_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic stop,
  input  logic lvl,
  output logic en
);

  logic low_phase;
  assign low_phase = ~lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         en <= 1'b1;
    else if (low_phase) en <= ~stop;
  end

  AST_EN_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(en) |-> !$past(lvl)); // R3
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !en) |=> (!en || !$past(stop))); // R2

endmodule

// File: rtl/sio_unit_freeze.sv
module sio_unit_freeze (
  input  logic clk,
  input  logic rst_n,
  input  logic frz_en,
  input  logic bnd,
  input  logic brk,
  output logic frozen
);

  logic may_halt;
  assign may_halt = frz_en & bnd & ~brk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        frozen <= 1'b0;
    else if (!frz_en)  frozen <= 1'b0;
    else if (may_halt) frozen <= 1'b1;
  end

  AST_HALT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frozen) |-> $past(bnd)); // R7
  AST_NO_HALT_IN_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
    (brk && !frozen) |=> !frozen); // R8
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !frz_en |=> !frozen); // R9

endmodule

// File: rtl/sio_cts_capture.sv
module sio_cts_capture
  import sio_pm_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           capsel,
  input  logic           xtal_lvl,
  input  logic           sclk_lvl,
  input  logic           xtal_en,
  input  logic           sclk_en,
  input  logic [NCH-1:0] cts_in,
  output logic [NCH-1:0] cts_q
);

  logic xtal_prev, sclk_prev;
  logic xtal_rise, sclk_rise, cap_edge;

  assign xtal_rise = rise(xtal_lvl, xtal_prev, xtal_en);
  assign sclk_rise = rise(sclk_lvl, sclk_prev, sclk_en);
  assign cap_edge  = capsel ? sclk_rise : xtal_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xtal_prev <= 1'b0;
      sclk_prev <= 1'b0;
    end else begin
      xtal_prev <= xtal_lvl;
      sclk_prev <= sclk_lvl;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cts_q[c] <= 1'b0;
      else if (cap_edge) cts_q[c] <= cts_in[c];
    end
  end

  AST_CTS_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cts_q) |-> $past(capsel ? sclk_lvl : xtal_lvl)); // R10

endmodule

// File: rtl/sio_pm_ctrl.sv
module sio_pm_ctrl
  import sio_pm_pkg::*;
#(
  parameter int NCH = 2,
  localparam int NUNIT = 2 * NCH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_req,
  input  logic             bus_wr,
  input  logic             cfg_sel,
  input  logic [CFG_W-1:0] bus_wdata,
  output logic [CFG_W-1:0] bus_rdata,
  output logic             bus_ack,
  output logic             bus_err,
  input  logic             xtal_lvl,
  input  logic             sclk_lvl,
  output logic             xtal_en,
  output logic             sclk_en,
  input  logic             dbg_freeze,
  input  logic [NUNIT-1:0] char_bnd,
  input  logic [NCH-1:0]   brk_active,
  output logic [NUNIT-1:0] frozen,
  input  logic [NCH-1:0]   cts_in,
  output logic [NCH-1:0]   cts_q
);

  sio_cfg_t cfg;
  logic     frz_en;

  assign frz_en = dbg_freeze & frz_honored(cfg.frz_mode);

  sio_cfg_bus u_bus (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .cfg_sel(cfg_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .bus_err(bus_err), .cfg(cfg)
  );

  sio_clk_gate u_gate_xtal (
    .clk(clk), .rst_n(rst_n), .stop(cfg.stop), .lvl(xtal_lvl), .en(xtal_en)
  );

  sio_clk_gate u_gate_sclk (
    .clk(clk), .rst_n(rst_n), .stop(cfg.stop), .lvl(sclk_lvl), .en(sclk_en)
  );

  for (genvar u = 0; u < NUNIT; u++) begin : g_unit
    logic brk_u;
    assign brk_u = unit_is_tx(u) ? brk_active[unit_chan(u)] : 1'b0;
    sio_unit_freeze u_frz (
      .clk(clk), .rst_n(rst_n), .frz_en(frz_en),
      .bnd(char_bnd[u]), .brk(brk_u), .frozen(frozen[u])
    );
  end

  sio_cts_capture #(.NCH(NCH)) u_cts (
    .clk(clk), .rst_n(rst_n), .capsel(cfg.capsel),
    .xtal_lvl(xtal_lvl), .sclk_lvl(sclk_lvl),
    .xtal_en(xtal_en), .sclk_en(sclk_en),
    .cts_in(cts_in), .cts_q(cts_q)
  );

  AST_IGNORED_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.frz_mode[1] |=> (frozen == '0)); // R6
  AST_STOPPED_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.stop && !xtal_lvl) |=> !xtal_en); // R2

endmodule

// File: tb/sio_pm_ctrl_tb_top.sv
module sio_pm_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;
  localparam int NUNIT = 2 * NCH;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_req = 0, bus_wr = 0, cfg_sel = 0;
  logic [3:0] bus_wdata = '0;
  logic [3:0] bus_rdata;
  logic bus_ack, bus_err;
  logic xtal_lvl = 0, sclk_lvl = 0;
  logic xtal_en, sclk_en;
  logic dbg_freeze = 0;
  logic [NUNIT-1:0] char_bnd = '0;
  logic [NCH-1:0] brk_active = '0;
  logic [NUNIT-1:0] frozen;
  logic [NCH-1:0] cts_in = '0;
  logic [NCH-1:0] cts_q;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sio_pm_ctrl #(.NCH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .cfg_sel(cfg_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .bus_err(bus_err), .xtal_lvl(xtal_lvl),
    .sclk_lvl(sclk_lvl), .xtal_en(xtal_en), .sclk_en(sclk_en),
    .dbg_freeze(dbg_freeze), .char_bnd(char_bnd), .brk_active(brk_active),
    .frozen(frozen), .cts_in(cts_in), .cts_q(cts_q)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic access(input logic sel, input logic wr, input logic [3:0] wd);
    cfg_sel = sel; bus_wr = wr; bus_wdata = wd; bus_req = 1'b1;
    tick(1);
    bus_req = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    access(1, 0, 0);
    check("R1 cfg", {4'b0, bus_rdata}, 8'h0);
    check("R1 ack", {7'b0, bus_ack}, 8'h1);
    check("R1 enables", {6'b0, xtal_en, sclk_en}, 8'h3);
    check("R1 frozen", {4'b0, frozen}, 8'h0);
    check("R1 cts", {6'b0, cts_q}, 8'h0);

    // R5 other register while running
    access(0, 0, 0);
    check("R5 run ack", {6'b0, bus_ack, bus_err}, 8'h2);

    // R2/R3 stop with serial clock high, crystal low
    sclk_lvl = 1; xtal_lvl = 0;
    access(1, 1, 4'b0001);
    tick(1);
    check("R2 xtal off", {7'b0, xtal_en}, 8'h0);
    check("R3 sclk held high", {7'b0, sclk_en}, 8'h1);
    sclk_lvl = 0;
    tick(1);
    check("R2 sclk off", {7'b0, sclk_en}, 8'h0);
    tick(3);
    check("R2 stays off", {6'b0, xtal_en, sclk_en}, 8'h0);

    // R5 error while stopped, R4 cfg readable
    access(0, 1, 4'hF);
    check("R5 stop err", {6'b0, bus_ack, bus_err}, 8'h1);
    access(1, 0, 0);
    check("R4 cfg read stopped", {3'b0, bus_ack, bus_rdata}, 8'h11);

    // R3 clear stop: crystal high holds enable off
    xtal_lvl = 1; sclk_lvl = 0;
    access(1, 1, 4'b0000);
    tick(1);
    check("R3 sclk back", {7'b0, sclk_en}, 8'h1);
    check("R3 xtal waits low", {7'b0, xtal_en}, 8'h0);
    xtal_lvl = 0;
    tick(1);
    check("R3 xtal back", {7'b0, xtal_en}, 8'h1);
    access(0, 0, 0);
    check("R5 after clear", {6'b0, bus_ack, bus_err}, 8'h2);

    // R6-R9 sweep: mode x unit x break
    for (int m = 0; m < 4; m++) begin
      access(1, 1, 4'(m << 1));
      access(1, 0, 0);
      check("R4 mode field", {4'b0, bus_rdata}, 8'(m << 1));
      for (int u = 0; u < NUNIT; u++) begin
        for (int b = 0; b < 2; b++) begin
          logic exp_f;
          brk_active = b[0] ? {NCH{1'b1}} : '0;
          dbg_freeze = 1;
          tick(1);
          check("R7 no boundary yet", {4'b0, frozen}, 8'h0);
          char_bnd = NUNIT'(1) << u;
          tick(1);
          char_bnd = '0;
          exp_f = (m >= 2) && !((u % 2 == 0) && b == 1);
          check(m < 2 ? "R6 ignored" : ((u % 2 == 0 && b == 1) ? "R8 break" : "R7 freeze"),
                {4'b0, frozen}, 8'(exp_f) << u);
          tick(1);
          check("R7 held", {4'b0, frozen}, 8'(exp_f) << u);
          dbg_freeze = 0;
          tick(1);
          check("R9 release", {4'b0, frozen}, 8'h0);
          brk_active = '0;
        end
      end
    end

    // R10 capture clock select
    access(1, 1, 4'b0000);
    xtal_lvl = 0; sclk_lvl = 0;
    tick(1);
    cts_in = 2'b01; sclk_lvl = 1;
    tick(1);
    check("R10 other clock ignored", {6'b0, cts_q}, 8'h0);
    sclk_lvl = 0; xtal_lvl = 1;
    tick(1);
    check("R10 xtal rise", {6'b0, cts_q}, 8'h1);
    cts_in = 2'b10;
    tick(2);
    check("R10 steady level", {6'b0, cts_q}, 8'h1);
    access(1, 1, 4'b1000);
    xtal_lvl = 0;
    tick(1);
    xtal_lvl = 1;
    tick(1);
    check("R10 xtal ignored when sclk selected", {6'b0, cts_q}, 8'h1);
    sclk_lvl = 1;
    tick(1);
    check("R10 sclk rise", {6'b0, cts_q}, 8'h2);

    tick(2);
    finish_run();
  end
endmodule